// File: doc/BRIEF.md
# Clock Buffer Power-up Sequencer

This block decides when the differential outputs of a clock buffer may start driving after power is applied. It steps through four states. In the off state the supply is not yet good. In the settle state a fixed delay runs. In the wait state the block holds until power-down is released and, in PLL mode, until the reference clock is qualified. In the run state the outputs are enabled. A digital supply-good flag takes the place of the analog threshold comparator. An active-low power-down request, a PLL-mode strap, an input-clock-valid flag and a PLL-locked flag complete the inputs.

The settle delay is counted in reference clock cycles. Its length comes from two parameters: the reference frequency in kHz and the delay in microseconds. The default is 250 us at 100 MHz, which leaves the whole power-up well under one millisecond.

A separate lock indicator latches the PLL-locked input. It holds until power-down is requested or the supply is lost.

State codes on `state_code` are 0 = OFF, 1 = SETTLE, 2 = WAIT, 3 = RUN. The named transitions are:
- OFF->SETTLE on supply good.
- SETTLE->WAIT on timer expiry.
- WAIT->RUN on release, qualified by mode.
- RUN->WAIT on power-down.
- ANY->OFF on supply loss.

Top module: `clkbuf_pwrseq`

## Requirements
- R1: After reset, `state_code` is 0 (OFF), `out_en` is 0 and `lock_out` is 0. The block stays in OFF for as long as `supply_ok` is low.
- R2: With `supply_ok` high in OFF, the block moves to SETTLE (code 1) on the next clock.
- R3: SETTLE lasts exactly SETTLE_CYCLES = REF_CLK_KHZ*SETTLE_US/1000 clock cycles, then the block moves to WAIT (code 2).
- R4: In WAIT with `pll_mode` low, the block moves to RUN (code 3) one clock after `pd_n` is high, whatever the values of `clk_valid` and `pll_locked`. While `pd_n` is low it stays in WAIT.
- R5: In WAIT with `pll_mode` high, the block moves to RUN only when `pd_n`, `clk_valid` and `pll_locked` are all high in the same cycle. Otherwise it stays in WAIT.
- R6: `out_en` is high exactly when `state_code` is 3.
- R7: `pd_n` low in RUN returns the block to WAIT on the next clock. A later drop of `clk_valid` or `pll_locked` does not make it leave RUN.
- R8: `supply_ok` low in any state returns the block to OFF on the next clock. The settle count restarts from zero on the next power-up.
- R9: `lock_out` goes high one clock after `pll_locked` is high while `supply_ok` and `pd_n` are high. It then stays high when `pll_locked` falls.
- R10: `lock_out` is cleared one clock after `pd_n` or `supply_ok` goes low. Clearing wins over a simultaneous set.
- R11: In bypass mode, with `pd_n` already high, `out_en` rises SETTLE_CYCLES+2 clocks after `supply_ok` rises. With the default parameters this is below 1 ms of reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above threshold |
| pd_n | input | 1 | Active-low power-down request |
| pll_mode | input | 1 | Strap: 1 = PLL mode, 0 = bypass |
| clk_valid | input | 1 | Input clock detected |
| pll_locked | input | 1 | PLL reports lock |
| out_en | output | 1 | Differential output enable |
| lock_out | output | 1 | Latched lock indicator |
| state_code | output | 2 | Current state code |

## Verification
The bench builds the block with REF_CLK_KHZ = 1000 and SETTLE_US = 8, so the settle window is 8 cycles. This short window lets every cycle of SETTLE be scored one by one. It also allows a power-up that is cut off partway through settle and then restarted to be measured against the full window. The default 25000-cycle window is checked only as arithmetic against the 1 ms bound, because stepping through it cycle by cycle adds nothing that the short window misses.

// File: rtl/clkbuf_pwrseq_pkg.sv
package clkbuf_pwrseq_pkg;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_SETTLE = 2'd1,
        PS_WAIT   = 2'd2,
        PS_RUN    = 2'd3
    } pwr_state_e;

    // Reference is good enough to enable outputs: always in bypass,
    // clock present and locked in PLL mode.
    function automatic logic ref_qualified(input logic pll_mode,
                                           input logic clk_valid,
                                           input logic pll_locked);
        return !pll_mode || (clk_valid && pll_locked);
    endfunction

endpackage

// File: rtl/clkbuf_settle_timer.sv
module clkbuf_settle_timer #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkbuf_lock_latch.sv
module clkbuf_lock_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pd_n,
    input  logic pll_locked,
    output logic lock_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (!supply_ok || !pd_n) begin
            lock_q <= 1'b0;
        end else if (pll_locked) begin
            lock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/clkbuf_pwrseq.sv
module clkbuf_pwrseq
    import clkbuf_pwrseq_pkg::*;
#(
    parameter int REF_CLK_KHZ = 100000,
    parameter int SETTLE_US   = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pd_n,
    input  logic       pll_mode,
    input  logic       clk_valid,
    input  logic       pll_locked,
    output logic       out_en,
    output logic       lock_out,
    output logic [1:0] state_code
);
    localparam int SETTLE_CYCLES = (REF_CLK_KHZ * SETTLE_US) / 1000;

    pwr_state_e state_q, state_d;
    logic       settle_done;
    logic       settle_run;

    assign settle_run = (state_q == PS_SETTLE);

    clkbuf_settle_timer #(
        .CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (settle_run),
        .done (settle_done)
    );

    clkbuf_lock_latch lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pd_n      (pd_n),
        .pll_locked(pll_locked),
        .lock_q    (lock_out)
    );

    // Next-state selection; supply loss overrides every state.
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:    state_d = PS_SETTLE;
                PS_SETTLE: if (settle_done) state_d = PS_WAIT;
                PS_WAIT:   if (pd_n && ref_qualified(pll_mode, clk_valid, pll_locked))
                               state_d = PS_RUN;
                PS_RUN:    if (!pd_n) state_d = PS_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        out_en = 1'b0;
        unique case (state_q)
            PS_OFF, PS_SETTLE, PS_WAIT: out_en = 1'b0;
            PS_RUN:                     out_en = 1'b1;
        endcase
        state_code = state_q;
    end
endmodule

// File: rtl/clkbuf_pwrseq_chk.sv
module clkbuf_pwrseq_chk #(
    parameter int SETTLE_CYCLES = 25000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       pd_n,
    input logic       pll_mode,
    input logic       clk_valid,
    input logic       pll_locked,
    input logic       out_en,
    input logic       lock_out,
    input logic [1:0] state_code
);
    int settle_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) settle_seen <= 0;
        else if (state_code == 2'd1) settle_seen <= settle_seen + 1;
        else settle_seen <= 0;
    end

    // R2
    off_to_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0 && supply_ok) |=> state_code == 2'd1);

    // R3
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd1) |-> (settle_seen < SETTLE_CYCLES));

    // R3
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd1 && supply_ok && settle_seen == SETTLE_CYCLES - 1)
        |=> state_code == 2'd2);

    // R5
    pll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd2 && pll_mode && !(clk_valid && pll_locked))
        |=> state_code != 2'd3);

    // R6
    enable_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> ($past(pd_n) && $past(supply_ok)));

    // R7
    run_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd3 && supply_ok && !pd_n) |=> state_code == 2'd2);

    // R8
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_code == 2'd0 && !out_en));

    // R9
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && pd_n && pll_locked) |=> lock_out);

    // R10
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || !pd_n) |=> !lock_out);
endmodule

bind clkbuf_pwrseq clkbuf_pwrseq_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .pd_n      (pd_n),
    .pll_mode  (pll_mode),
    .clk_valid (clk_valid),
    .pll_locked(pll_locked),
    .out_en    (out_en),
    .lock_out  (lock_out),
    .state_code(state_code)
);

// File: tb/clkbuf_pwrseq_tb_top.sv
module clkbuf_pwrseq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ        = 1000;
    localparam int US         = 8;
    localparam int N          = KHZ * US / 1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok, pd_n, pll_mode, clk_valid, pll_locked;
    logic       out_en, lock_out;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    typedef struct {
        logic [1:0] st;
        logic       lk;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkbuf_pwrseq #(
        .REF_CLK_KHZ(KHZ),
        .SETTLE_US  (US)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pd_n      (pd_n),
        .pll_mode  (pll_mode),
        .clk_valid (clk_valid),
        .pll_locked(pll_locked),
        .out_en    (out_en),
        .lock_out  (lock_out),
        .state_code(state_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: apply inputs before an edge and queue what must follow it.
    task automatic cyc(input logic sup, input logic pd, input logic pm,
                       input logic cv, input logic lk,
                       input logic [1:0] est, input logic elk, input string tag);
        exp_t e;
        @(negedge clk);
        supply_ok  = sup;
        pd_n       = pd;
        pll_mode   = pm;
        clk_valid  = cv;
        pll_locked = lk;
        e.st  = est;
        e.lk  = elk;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (state_code !== e.st || out_en !== (e.st == 2'd3) || lock_out !== e.lk) begin
                    errors++;
                    $display("FAIL %s actual st=%0d en=%0b lk=%0b expected st=%0d en=%0b lk=%0b",
                             e.tag, state_code, out_en, lock_out, e.st, (e.st == 2'd3), e.lk);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int lat;
        rst_n = 1'b0;
        supply_ok = 0; pd_n = 0; pll_mode = 0; clk_valid = 0; pll_locked = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(state_code == 2'd0, "R1 reset state", state_code, 0);
        chk(out_en == 1'b0, "R1 reset out_en", out_en, 0);
        chk(lock_out == 1'b0, "R1 reset lock", lock_out, 0);
        repeat (3) cyc(0, 0, 0, 0, 0, 2'd0, 0, "R1 hold off");

        // Bypass power-up
        cyc(1, 0, 0, 0, 0, 2'd1, 0, "R2 enter settle");
        for (int i = 1; i < N; i++) cyc(1, 0, 0, 0, 0, 2'd1, 0, "R3 in settle");
        cyc(1, 0, 0, 0, 0, 2'd2, 0, "R3 settle exit");
        repeat (2) cyc(1, 0, 0, 0, 0, 2'd2, 0, "R4 held by pd");
        cyc(1, 1, 0, 0, 0, 2'd3, 0, "R4 R6 bypass release");
        cyc(1, 0, 0, 0, 0, 2'd2, 0, "R7 pd in run");
        cyc(1, 1, 0, 0, 0, 2'd3, 0, "R7 rerelease");
        cyc(1, 1, 0, 1, 1, 2'd3, 1, "R9 lock set");
        cyc(1, 1, 0, 0, 0, 2'd3, 1, "R9 lock latched");
        cyc(1, 0, 0, 0, 0, 2'd2, 0, "R10 pd clears lock");
        cyc(1, 0, 0, 1, 1, 2'd2, 0, "R10 clear wins");
        cyc(0, 1, 0, 0, 1, 2'd0, 0, "R8 supply loss from wait");

        // PLL mode, with a power-up cut off during settle
        cyc(1, 1, 1, 0, 0, 2'd1, 0, "R2 pll enter settle");
        repeat (3) cyc(1, 1, 1, 0, 0, 2'd1, 0, "R3 pll settle");
        cyc(0, 1, 1, 0, 0, 2'd0, 0, "R8 loss mid settle");
        cyc(1, 1, 1, 0, 0, 2'd1, 0, "R8 restart settle");
        for (int i = 1; i < N; i++) cyc(1, 1, 1, 0, 0, 2'd1, 0, "R8 full count again");
        cyc(1, 1, 1, 0, 0, 2'd2, 0, "R3 pll settle exit");
        repeat (2) cyc(1, 1, 1, 0, 0, 2'd2, 0, "R5 no clock");
        cyc(1, 1, 1, 1, 0, 2'd2, 0, "R5 no lock");
        cyc(1, 1, 1, 0, 1, 2'd2, 1, "R5 lock without clock");
        cyc(1, 1, 1, 1, 1, 2'd3, 1, "R5 R6 qualified");
        cyc(1, 1, 1, 0, 0, 2'd3, 1, "R7 R9 stays in run");
        cyc(1, 0, 1, 1, 1, 2'd2, 0, "R7 R10 pd in pll run");
        cyc(1, 1, 1, 1, 1, 2'd3, 1, "R5 relock");
        cyc(0, 1, 1, 1, 1, 2'd0, 0, "R8 R10 supply loss in run");

        wait (sb_q.size() == 0);
        @(posedge clk);

        // R11 latency in bypass mode
        @(negedge clk);
        supply_ok = 1; pd_n = 1; pll_mode = 0; clk_valid = 0; pll_locked = 0;
        lat = 0;
        while (!out_en && lat < N + 20) begin
            @(posedge clk);
            #1;
            lat++;
        end
        chk(lat == N + 2, "R11 latency cycles", lat, N + 2);
        chk(lat < KHZ, "R11 under 1 ms", lat, KHZ);
        chk((100000 * 250 / 1000 + 2) < 100000, "R11 default under 1 ms",
            100000 * 250 / 1000 + 2, 100000);

        finish_run();
    end
endmodule